// File: doc/BRIEF.md
# Per-Port Source Address Guard Store

This block keeps a short whitelist of permitted station addresses for each port of a 13-port repeater. Each port has two 48-bit slots. The block watches the decoded receive byte stream. When the source address of a frame has fully arrived, it compares that address with the valid slots of the receiving port. If the address is not in any valid slot, it raises a select. The select tells the transmit path to replace the rest of the frame with a random pattern, both on the local ports and on the bus between repeater chips. The pattern generator itself sits outside this block.

A slot gets its contents in one of two ways. With a port's learn enable set, a frame that ends with a good CRC writes its source address into that port's slots. Slots fill in order: first slot 0, then slot 1, then each one in turn. A byte-wide processor port can also read and write the slots, but only for a port whose learn enable is clear.

The receive stream has valid only and no back-pressure. The block only observes the stream and accepts a byte in every cycle where `rx_valid` is high. The processor port completes every access in one cycle, and its result appears on the next cycle.

Top module: `sa_guard_cam`

## Requirements
- R1: After reset, every slot is invalid, and `scramble_sel`, `cpu_err` and `cpu_rdata` are 0.
- R2: A frame starts with a byte where `rx_valid` and `rx_sof` are both high (stream index 0), and its port is taken from `rx_port` on that byte. Stream bytes 6 to 11 carry the source address. Stream byte 6 is address byte 0, which is bits 7:0, and so on up to byte 11, which is bits 47:40.
- R3: A port with no valid slot never raises `scramble_sel`, whatever the source address.
- R4: If the source address matches no valid slot of its port, `scramble_sel` is high from the cycle after byte 11 is accepted. It stays high until it is cleared, and it is low on the cycle after `rx_eof` or after the next frame start.
- R5: A source address equal to any valid slot of its port leaves `scramble_sel` low.
- R6: A learn write happens only when `rx_eof` and `rx_crc_ok` are high in the same cycle, after a full source address, with `learn_en` set for the frame's port. Without a good CRC, or with learn enable clear, nothing is stored.
- R7: Learned addresses fill slot 0 first and then slot 1. Once both slots are valid, later learn writes replace slot 0, then slot 1, and keep alternating per port.
- R8: A learned address already held in a valid slot of the port is not written again, and the replacement order does not advance.
- R9: A processor access is refused if `learn_en` is set for `cpu_port`, if `cpu_port` is 13 or higher, or if `cpu_idx` is 6 or higher. A refused access gives `cpu_err` = 1 and `cpu_rdata` = 0 on the next cycle and changes no slot.
- R10: An accepted read (`cpu_wr` = 0) returns byte `cpu_idx` of slot `cpu_slot` on the next cycle. An accepted write stores that byte, and only a write to byte index 5 marks the slot valid.
- R11: A learn write on one port and an accepted processor write on another port in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| learn_en | input | 13 | Per-port learn enable |
| rx_valid | input | 1 | Receive byte valid |
| rx_sof | input | 1 | First byte of a frame |
| rx_port | input | 4 | Receiving port, taken at frame start |
| rx_byte | input | 8 | Receive data byte |
| rx_eof | input | 1 | End-of-frame strobe |
| rx_crc_ok | input | 1 | CRC-good strobe, qualified by rx_eof |
| scramble_sel | output | 1 | Replace outgoing data with random pattern |
| cpu_en | input | 1 | Processor access strobe |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_port | input | 4 | Port addressed |
| cpu_slot | input | 1 | Slot addressed |
| cpu_idx | input | 3 | Address byte index, 0 = bits 7:0 |
| cpu_wdata | input | 8 | Write byte |
| cpu_rdata | output | 8 | Read byte, one cycle after access |
| cpu_err | output | 1 | Access refused, one cycle after access |

## Verification
A learn commit on one port and a processor write to another port can fall in the same clock edge, and both update the shared slot storage. The bench creates this case by driving a processor write to port 4 during the end-of-frame cycle of a good-CRC frame on port 3 while port 3 is learning. It then judges the result by reading back both slots. It also sends a frame to port 4, whose slot has now become valid, and expects that frame to be scrambled.

// File: rtl/sa_cam_pkg.sv
`timescale 1ns/1ps
package sa_cam_pkg;
  localparam int ADDR_BYTES = 6;
  localparam int AW         = ADDR_BYTES * 8;
  localparam int SA_FIRST   = 6;
  localparam int SA_LAST    = SA_FIRST + ADDR_BYTES - 1;
  typedef logic [AW-1:0] mac_t;
endpackage

// File: rtl/sa_rx_tracker.sv
`timescale 1ns/1ps
// Follows the receive stream: frame port, byte position, source address capture.
module sa_rx_tracker
  import sa_cam_pkg::*;
#(
  parameter int NPORT = 13,
  parameter int PW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_valid,
  input  logic          rx_sof,
  input  logic [PW-1:0] rx_port,
  input  logic [7:0]    rx_byte,
  input  logic          rx_eof,
  output logic [PW-1:0] frm_port,
  output logic          port_ok,
  output logic          sa_last,
  output mac_t          sa_full,
  output mac_t          sa_held,
  output logic          sa_done
);
  localparam int CW = 4;

  logic [CW-1:0] cnt_q;
  logic          in_frm_q;
  logic          mid;

  assign mid      = rx_valid && !rx_sof && in_frm_q;
  assign sa_last  = mid && (cnt_q == CW'(SA_LAST));
  assign sa_full  = {rx_byte, sa_held[AW-9:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      in_frm_q <= 1'b0;
      frm_port <= '0;
      port_ok  <= 1'b0;
      sa_held  <= '0;
      sa_done  <= 1'b0;
    end else begin
      if (rx_valid && rx_sof) begin
        cnt_q    <= CW'(1);
        in_frm_q <= 1'b1;
        frm_port <= rx_port;
        port_ok  <= int'(rx_port) < NPORT;
        sa_done  <= 1'b0;
      end else if (mid) begin
        if (cnt_q != '1) cnt_q <= cnt_q + 1'b1;
        for (int b = 0; b < ADDR_BYTES; b++) begin
          if (cnt_q == CW'(SA_FIRST + b)) sa_held[b*8 +: 8] <= rx_byte;
        end
        if (sa_last) sa_done <= 1'b1;
      end
      if (rx_eof) begin
        in_frm_q <= 1'b0;
        sa_done  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sa_match.sv
`timescale 1ns/1ps
// Compares one key against the slots of a port.
module sa_match
  import sa_cam_pkg::*;
#(
  parameter int NSLOT = 2
) (
  input  mac_t             key,
  input  mac_t             slot_addr [NSLOT],
  input  logic [NSLOT-1:0] slot_vld,
  output logic             hit,
  output logic             any_vld
);
  logic [NSLOT-1:0] eq;

  for (genvar s = 0; s < NSLOT; s++) begin : g_cmp
    assign eq[s] = slot_vld[s] && (slot_addr[s] == key);
  end

  assign hit     = |eq;
  assign any_vld = |slot_vld;
endmodule

// File: rtl/sa_slot_store.sv
`timescale 1ns/1ps
// Slot storage, valid bits, replacement pointers and processor access.
module sa_slot_store
  import sa_cam_pkg::*;
#(
  parameter int NPORT = 13,
  parameter int PW    = 4,
  parameter int NSLOT = 2,
  parameter int SW    = 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NPORT-1:0]           learn_en,
  input  logic                       lrn_we,
  input  logic [PW-1:0]              lrn_port,
  input  mac_t                       lrn_addr,
  input  logic                       cpu_en,
  input  logic                       cpu_wr,
  input  logic [PW-1:0]              cpu_port,
  input  logic [SW-1:0]              cpu_slot,
  input  logic [2:0]                 cpu_idx,
  input  logic [7:0]                 cpu_wdata,
  output logic [7:0]                 cpu_rdata,
  output logic                       cpu_err,
  output mac_t                       slot_addr [NPORT][NSLOT],
  output logic [NPORT-1:0][NSLOT-1:0] slot_vld
);
  logic [NPORT-1:0][SW-1:0] rr_q;
  logic                     port_in;
  logic                     refuse;
  logic                     cpu_we;
  logic [SW-1:0]            victim;
  logic                     full;

  assign port_in = int'(cpu_port) < NPORT;
  assign refuse  = !port_in || (int'(cpu_idx) >= ADDR_BYTES) || learn_en[cpu_port];
  assign cpu_we  = cpu_en && cpu_wr && !refuse;
  assign full    = &slot_vld[lrn_port];

  // Lowest invalid slot first, else the round-robin pointer.
  always_comb begin
    victim = rr_q[lrn_port];
    for (int s = NSLOT - 1; s >= 0; s--) begin
      if (!slot_vld[lrn_port][s]) victim = SW'(s);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_vld  <= '0;
      rr_q      <= '0;
      cpu_rdata <= '0;
      cpu_err   <= 1'b0;
    end else begin
      cpu_err   <= cpu_en && refuse;
      cpu_rdata <= (cpu_en && !cpu_wr && !refuse)
                   ? slot_addr[cpu_port][cpu_slot][cpu_idx*8 +: 8] : 8'h00;
      if (lrn_we) begin
        slot_vld[lrn_port][victim] <= 1'b1;
        if (full) begin
          rr_q[lrn_port] <= (int'(rr_q[lrn_port]) == NSLOT - 1) ? '0 : rr_q[lrn_port] + 1'b1;
        end
      end
      if (cpu_we && cpu_idx == 3'(ADDR_BYTES - 1)) slot_vld[cpu_port][cpu_slot] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (lrn_we) slot_addr[lrn_port][victim] <= lrn_addr;
    if (cpu_we) slot_addr[cpu_port][cpu_slot][cpu_idx*8 +: 8] <= cpu_wdata;
  end
endmodule

// File: rtl/sa_guard_cam.sv
`timescale 1ns/1ps
// Per-port source address whitelist with learning and scramble select.
module sa_guard_cam
  import sa_cam_pkg::*;
#(
  parameter int NPORT = 13,
  parameter int PW    = $clog2(NPORT),
  parameter int NSLOT = 2,
  parameter int SW    = $clog2(NSLOT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPORT-1:0] learn_en,
  input  logic             rx_valid,
  input  logic             rx_sof,
  input  logic [PW-1:0]    rx_port,
  input  logic [7:0]       rx_byte,
  input  logic             rx_eof,
  input  logic             rx_crc_ok,
  output logic             scramble_sel,
  input  logic             cpu_en,
  input  logic             cpu_wr,
  input  logic [PW-1:0]    cpu_port,
  input  logic [SW-1:0]    cpu_slot,
  input  logic [2:0]       cpu_idx,
  input  logic [7:0]       cpu_wdata,
  output logic [7:0]       cpu_rdata,
  output logic             cpu_err
);
  logic [PW-1:0] frm_port;
  logic [PW-1:0] port_sel;
  logic          port_ok;
  logic          sa_last;
  logic          sa_done;
  mac_t          sa_full;
  mac_t          sa_held;
  mac_t          slot_addr [NPORT][NSLOT];
  logic [NPORT-1:0][NSLOT-1:0] slot_vld;
  mac_t          cur_addr [NSLOT];
  logic          chk_hit, chk_any;
  logic          lrn_hit, lrn_any;
  logic          lrn_we;
  logic          scram_q;

  sa_rx_tracker #(.NPORT(NPORT), .PW(PW)) u_trk (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof),
    .rx_port(rx_port), .rx_byte(rx_byte), .rx_eof(rx_eof),
    .frm_port(frm_port), .port_ok(port_ok), .sa_last(sa_last),
    .sa_full(sa_full), .sa_held(sa_held), .sa_done(sa_done)
  );

  assign port_sel = port_ok ? frm_port : '0;

  always_comb begin
    for (int s = 0; s < NSLOT; s++) cur_addr[s] = slot_addr[port_sel][s];
  end

  sa_match #(.NSLOT(NSLOT)) u_chk_cmp (
    .key(sa_full), .slot_addr(cur_addr), .slot_vld(slot_vld[port_sel]),
    .hit(chk_hit), .any_vld(chk_any)
  );

  sa_match #(.NSLOT(NSLOT)) u_lrn_cmp (
    .key(sa_held), .slot_addr(cur_addr), .slot_vld(slot_vld[port_sel]),
    .hit(lrn_hit), .any_vld(lrn_any)
  );

  assign lrn_we = rx_eof && rx_crc_ok && sa_done && port_ok
                  && learn_en[port_sel] && !lrn_hit;

  sa_slot_store #(.NPORT(NPORT), .PW(PW), .NSLOT(NSLOT), .SW(SW)) u_store (
    .clk(clk), .rst_n(rst_n), .learn_en(learn_en),
    .lrn_we(lrn_we), .lrn_port(port_sel), .lrn_addr(sa_held),
    .cpu_en(cpu_en), .cpu_wr(cpu_wr), .cpu_port(cpu_port), .cpu_slot(cpu_slot),
    .cpu_idx(cpu_idx), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .cpu_err(cpu_err), .slot_addr(slot_addr), .slot_vld(slot_vld)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scram_q <= 1'b0;
    end else if (rx_eof || (rx_valid && rx_sof)) begin
      scram_q <= 1'b0;
    end else if (sa_last) begin
      scram_q <= port_ok && chk_any && !chk_hit;
    end
  end

  assign scramble_sel = scram_q;

  logic unused_ok;
  assign unused_ok = lrn_any;
endmodule

// File: rtl/sa_guard_cam_chk.sv
`timescale 1ns/1ps
module sa_guard_cam_chk #(
  parameter int NPORT = 13,
  parameter int PW    = 4,
  parameter int SW    = 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NPORT-1:0] learn_en,
  input logic             rx_valid,
  input logic             rx_sof,
  input logic             rx_eof,
  input logic             scramble_sel,
  input logic             cpu_en,
  input logic [PW-1:0]    cpu_port,
  input logic [7:0]       cpu_rdata,
  input logic             cpu_err
);
  assert_refuse_learning_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_en && int'(cpu_port) < NPORT && learn_en[cpu_port]) |=> (cpu_err && cpu_rdata == 8'h00));

  assert_no_err_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_en |=> !cpu_err);

  assert_err_blank_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_err |-> cpu_rdata == 8'h00);

  assert_scram_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_eof || (rx_valid && rx_sof)) |=> !scramble_sel);

  assert_scram_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (scramble_sel && !rx_eof && !(rx_valid && rx_sof) && !rx_valid) |=> scramble_sel);

  assert_scram_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scramble_sel) |-> $past(rx_valid && !rx_sof));
endmodule

bind sa_guard_cam sa_guard_cam_chk #(.NPORT(NPORT), .PW(PW), .SW(SW)) u_guard_chk (
  .clk(clk), .rst_n(rst_n), .learn_en(learn_en), .rx_valid(rx_valid),
  .rx_sof(rx_sof), .rx_eof(rx_eof), .scramble_sel(scramble_sel),
  .cpu_en(cpu_en), .cpu_port(cpu_port), .cpu_rdata(cpu_rdata), .cpu_err(cpu_err)
);

// File: tb/test_sa_guard_cam.sv
`timescale 1ns/1ps
module test_sa_guard_cam;
  localparam int NPORT = 13;
  localparam int PW    = 4;

  localparam logic [47:0] SA_A = 48'h11_22_33_44_55_66;
  localparam logic [47:0] SA_B = 48'hA1_B2_C3_D4_E5_F6;
  localparam logic [47:0] SA_C = 48'h0C_1C_2C_3C_4C_5C;
  localparam logic [47:0] SA_D = 48'hD0_D1_D2_D3_D4_D5;
  localparam logic [47:0] SA_E = 48'hEE_01_02_03_04_05;
  localparam logic [47:0] SA_F = 48'hF0_F1_F2_F3_F4_F5;
  localparam logic [47:0] SA_G = 48'h60_61_62_63_64_65;
  localparam logic [47:0] SA_Q = 48'h99_88_77_66_55_44;

  typedef struct packed {
    logic [3:0]  port;
    logic [47:0] sa;
    logic        crc;
    logic        lrn;
    logic        exp;
  } row_t;

  // R3 R4 R5 R6 R7 walked in order
  localparam row_t TBL [10] = '{
    '{4'd1, SA_A, 1'b1, 1'b1, 1'b0},  // empty port: no scramble, learn A -> slot0
    '{4'd1, SA_A, 1'b1, 1'b1, 1'b0},  // match, already held
    '{4'd1, SA_B, 1'b0, 1'b1, 1'b1},  // mismatch, bad CRC: not learned
    '{4'd1, SA_B, 1'b1, 1'b1, 1'b1},  // mismatch, learn B -> slot1
    '{4'd1, SA_C, 1'b1, 1'b0, 1'b1},  // learn off: not learned
    '{4'd1, SA_B, 1'b1, 1'b0, 1'b0},  // B held
    '{4'd2, SA_C, 1'b1, 1'b1, 1'b0},  // other port empty, learn C
    '{4'd1, SA_C, 1'b1, 1'b1, 1'b1},  // full: C replaces slot0
    '{4'd1, SA_A, 1'b1, 1'b0, 1'b1},  // A gone
    '{4'd1, SA_C, 1'b1, 1'b0, 1'b0}   // C held
  };

  logic             clk = 1'b0;
  logic             rst_n;
  logic [NPORT-1:0] learn_en;
  logic             rx_valid, rx_sof, rx_eof, rx_crc_ok;
  logic [PW-1:0]    rx_port;
  logic [7:0]       rx_byte;
  logic             scramble_sel;
  logic             cpu_en, cpu_wr;
  logic [PW-1:0]    cpu_port;
  logic [0:0]       cpu_slot;
  logic [2:0]       cpu_idx;
  logic [7:0]       cpu_wdata, cpu_rdata;
  logic             cpu_err;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  sa_guard_cam #(.NPORT(NPORT)) i_sa_guard_cam (
    .clk(clk), .rst_n(rst_n), .learn_en(learn_en), .rx_valid(rx_valid),
    .rx_sof(rx_sof), .rx_port(rx_port), .rx_byte(rx_byte), .rx_eof(rx_eof),
    .rx_crc_ok(rx_crc_ok), .scramble_sel(scramble_sel), .cpu_en(cpu_en),
    .cpu_wr(cpu_wr), .cpu_port(cpu_port), .cpu_slot(cpu_slot), .cpu_idx(cpu_idx),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_err(cpu_err)
  );

  task automatic check(input bit ok, input string req, input logic [47:0] act, input logic [47:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_frame(input int port, input logic [47:0] sa, input bit crc, input bit exp,
                            input string req, input bit side, input int sport, input logic [7:0] sdata);
    for (int i = 0; i < 14; i++) begin
      @(negedge clk);
      if (i == 12) check(scramble_sel == exp, req, 48'(scramble_sel), 48'(exp));
      rx_valid = 1'b1;
      rx_sof   = (i == 0);
      rx_port  = PW'(port);
      rx_byte  = (i >= 6 && i < 12) ? sa[(i-6)*8 +: 8] : 8'(8'h50 + i);
    end
    @(negedge clk);
    check(scramble_sel == exp, {req, " held R4"}, 48'(scramble_sel), 48'(exp));
    rx_valid  = 1'b0;
    rx_sof    = 1'b0;
    rx_eof    = 1'b1;
    rx_crc_ok = crc;
    if (side) begin
      cpu_en = 1'b1; cpu_wr = 1'b1; cpu_port = PW'(sport);
      cpu_slot = 1'b0; cpu_idx = 3'd5; cpu_wdata = sdata;
    end
    @(negedge clk);
    rx_eof = 1'b0; rx_crc_ok = 1'b0; cpu_en = 1'b0; cpu_wr = 1'b0;
    check(scramble_sel == 1'b0, "R4 clear after eof", 48'(scramble_sel), 48'h0);
  endtask

  task automatic cpu_acc(input int port, input int slot, input int idx, input bit wr,
                         input logic [7:0] wd, output logic [7:0] rd, output logic err);
    @(negedge clk);
    cpu_en = 1'b1; cpu_wr = wr; cpu_port = PW'(port); cpu_slot = 1'(slot);
    cpu_idx = 3'(idx); cpu_wdata = wd;
    @(negedge clk);
    cpu_en = 1'b0; cpu_wr = 1'b0;
    rd = cpu_rdata; err = cpu_err;
  endtask

  task automatic read_mac(input int port, input int slot, output logic [47:0] mac);
    logic [7:0] rd;
    logic       err;
    mac = '0;
    for (int b = 0; b < 6; b++) begin
      cpu_acc(port, slot, b, 1'b0, 8'h00, rd, err);
      mac[b*8 +: 8] = rd;
    end
  endtask

  initial begin
    #(4 * 100000);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [47:0] mac;
    logic [7:0]  rd;
    logic        err;
    rst_n = 1'b0; learn_en = '0; rx_valid = 0; rx_sof = 0; rx_eof = 0; rx_crc_ok = 0;
    rx_port = '0; rx_byte = '0; cpu_en = 0; cpu_wr = 0; cpu_port = '0; cpu_slot = '0;
    cpu_idx = '0; cpu_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(scramble_sel == 0, "R1 scramble reset", 48'(scramble_sel), 48'h0);
    check(cpu_err == 0, "R1 err reset", 48'(cpu_err), 48'h0);
    check(cpu_rdata == 0, "R1 rdata reset", 48'(cpu_rdata), 48'h0);

    for (int i = 0; i < 10; i++) begin
      learn_en = '0;
      learn_en[TBL[i].port] = TBL[i].lrn;
      send_frame(int'(TBL[i].port), TBL[i].sa, TBL[i].crc, TBL[i].exp,
                 $sformatf("%s row %0d", TBL[i].exp ? "R4 mismatch" : "R5 R3 R6 match", i),
                 1'b0, 0, 8'h00);
    end
    learn_en = '0;

    read_mac(1, 0, mac); check(mac == SA_C, "R7 port1 slot0 replaced", mac, SA_C);
    read_mac(1, 1, mac); check(mac == SA_B, "R7 R6 port1 slot1", mac, SA_B);
    read_mac(2, 0, mac); check(mac == SA_C, "R2 byte order port2 slot0", mac, SA_C);

    // R8: relearn of held C must not advance replacement order
    learn_en[1] = 1'b1;
    send_frame(1, SA_C, 1'b1, 1'b0, "R8 held match", 1'b0, 0, 8'h00);
    send_frame(1, SA_D, 1'b1, 1'b1, "R8 new addr mismatch", 1'b0, 0, 8'h00);
    learn_en = '0;
    read_mac(1, 0, mac); check(mac == SA_C, "R8 slot0 kept", mac, SA_C);
    read_mac(1, 1, mac); check(mac == SA_D, "R8 slot1 replaced", mac, SA_D);

    // R9: refused accesses
    learn_en[1] = 1'b1;
    cpu_acc(1, 0, 0, 1'b1, 8'hFF, rd, err);
    check(err == 1'b1, "R9 write refused while learning", 48'(err), 48'h1);
    cpu_acc(1, 0, 1, 1'b0, 8'h00, rd, err);
    check(err == 1'b1 && rd == 8'h00, "R9 read refused while learning", {rd, 7'h0, err}, 48'h1);
    learn_en = '0;
    cpu_acc(1, 0, 0, 1'b0, 8'h00, rd, err);
    check(err == 1'b0 && rd == SA_C[7:0], "R9 refused write left slot", 48'(rd), 48'(SA_C[7:0]));
    cpu_acc(13, 0, 0, 1'b0, 8'h00, rd, err);
    check(err == 1'b1 && rd == 8'h00, "R9 port 13 refused", 48'(err), 48'h1);
    cpu_acc(1, 0, 6, 1'b0, 8'h00, rd, err);
    check(err == 1'b1 && rd == 8'h00, "R9 index 6 refused", 48'(err), 48'h1);

    // R10: partial write does not validate, byte 5 does
    for (int b = 0; b < 5; b++) cpu_acc(6, 0, b, 1'b1, SA_F[b*8 +: 8], rd, err);
    send_frame(6, SA_G, 1'b1, 1'b0, "R10 slot not yet valid", 1'b0, 0, 8'h00);
    cpu_acc(6, 0, 5, 1'b1, SA_F[47:40], rd, err);
    check(err == 1'b0, "R10 write accepted", 48'(err), 48'h0);
    send_frame(6, SA_G, 1'b1, 1'b1, "R10 valid slot rejects G", 1'b0, 0, 8'h00);
    send_frame(6, SA_F, 1'b1, 1'b0, "R10 written addr matches", 1'b0, 0, 8'h00);
    cpu_acc(6, 0, 2, 1'b0, 8'h00, rd, err);
    check(rd == SA_F[23:16], "R10 read byte 2", 48'(rd), 48'(SA_F[23:16]));

    // R11: learn on port 3 and processor write on port 4 in one cycle
    learn_en[3] = 1'b1;
    send_frame(3, SA_E, 1'b1, 1'b0, "R11 empty port3", 1'b1, 4, 8'h77);
    learn_en = '0;
    read_mac(3, 0, mac); check(mac == SA_E, "R11 learned port3", mac, SA_E);
    cpu_acc(4, 0, 5, 1'b0, 8'h00, rd, err);
    check(rd == 8'h77, "R11 side write port4", 48'(rd), 48'h77);
    send_frame(4, SA_E, 1'b1, 1'b1, "R11 port4 slot now valid", 1'b0, 0, 8'h00);

    // R1: reset clears validity
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check(scramble_sel == 0 && cpu_err == 0, "R1 after mid reset", 48'(scramble_sel), 48'h0);
    send_frame(1, SA_Q, 1'b1, 1'b0, "R1 R3 slots invalid after reset", 1'b0, 0, 8'h00);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule